// File: doc/BRIEF.md
# Register-Mapped SPI Flash Master

This block is a SPI master for serial NOR flash. A host drives it through a small 32-bit register bus. Software fills a 64-byte data buffer, sets how many bits to shift, chooses the chip-select level and hold behaviour, picks the clock polarity and the length of each SCK half-period, and then writes a start bit. The controller shifts the buffer out on MOSI and captures MISO back into the same buffer positions. When the last bit has shifted, it raises a done flag.

Chip select can stay asserted across successive starts. This lets a flash command longer than one buffer load (opcode, address, then data chunks) run as one continuous CS window. A soft-reset bit aborts a transfer at any point. A read-path enable bit and an operating-mode bit both block starts while they are set.

Top module: `sfc_master`

## Requirements
- R1: After reset: cs_o is 1 (inactive, active-low), sck_o is 0 and mosi_o is 0. The control register (0x08) reads 0x0002_0000, with its read-path enable at bit 17. The status register (0x30) and the clock register (0x18) read 0.
- R2: The configuration fields read back where they were written, and every other bit reads 0. The masks are: clock 0x18 → 0x8003_FFFF; user 0x1C → 0x0800_0081; count 0x20 → 0x03FE_0000; chip-select 0x2C → 0x4080_0000. The command register 0x00 reads 0.
- R3: Writing 1 to bit 18 of 0x00 starts a transfer only when three conditions hold: no transfer is running, control bit 17 is 0, and status bit 30 (mode, 0 = master) is 0. Otherwise the write changes nothing on the pins.
- R4: A transfer shifts (0x20 bits [25:17]) + 1 bits. Buffer byte b sits in word 0x40 + 4·(b/4), bits 8·(b%4)+7 … 8·(b%4). Byte 0 goes first, and each byte is sent MSB first.
- R5: SCK rests at the level of user bit 7. For each bit, SCK stays at the rest level for (0x18 bits [5:0]) + 1 cycles, then at the opposite level for (0x18 bits [11:6]) + 1 cycles. MOSI changes only while SCK is at the rest level.
- R6: When user bit 0 is 1, MISO is sampled as SCK leaves its rest level, and the sample replaces the buffer bit that was just sent. When user bit 0 is 0, the buffer is not changed.
- R7: When user bit 27 is 0, MOSI stays 0 for the whole transfer.
- R8: CS is asserted from the start until the end of the last bit. Its active level is high when 0x2C bit 23 is 1 and low otherwise. At the end, CS is released if 0x2C bit 30 is 0 and stays asserted if it is 1, including through the next start.
- R9: Status bit 4 (done) sets at the end of the last bit. Writing 0 to it clears it. Writing 1 to it does not set it.
- R10: Writing 1 to status bit 31 aborts any transfer, releases CS, clears done, and reads back as 0. The configuration registers are kept.
- R11: A start written while a transfer runs is ignored, and the running transfer keeps its length and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| sck_o | output | 1 | Serial clock |
| cs_o | output | 1 | Chip select |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Transfers run with several settings: symmetric, asymmetric and minimum half-period counts; both clock polarities; both chip-select levels; lengths of 2 to 64 bytes. A bench model derives every cycle of SCK, CS and MOSI from arithmetic on the cycle index, so an off-by-one in a half-period count, in the bit order or in the byte lane shows as a waveform mismatch. A pair of chained transfers with CS held tells hold-and-chain apart from release-at-end. Capture on and off, data-out off, and a start during a transfer each isolate one control bit. Starts blocked by the read-path bit and by the mode bit, plus a mid-transfer abort, cover the paths that must leave the pins quiet.

// File: rtl/sfc_master.sv
module sfc_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [6:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sck_o,
  output logic        cs_o,
  output logic        mosi_o,
  input  logic        miso_i
);
  localparam int BUF_BYTES = 64;
  localparam int BUF_BITS  = BUF_BYTES * 8;
  localparam int IW        = $clog2(BUF_BITS);
  localparam int HW        = 6;

  logic          mmap_en, clk_src, din_en, cpol, dout_sel, cs_hi, cs_hold, slave_mode, done;
  logic [HW-1:0] div_n, hi_cnt, lo_cnt, ph_cnt;
  logic [IW-1:0] cnt_m1, bit_idx, pos;
  logic [BUF_BITS-1:0] buf_q;
  logic          busy, act, rx_bit, cs_act;

  logic [4:0] widx;
  logic       wr, start_req, srst, start_ok, bit_end, last;

  assign widx      = bus_addr[6:2];
  assign wr        = bus_sel & bus_wr;
  assign start_req = wr && widx == 5'd0 && bus_wdata[18];
  assign srst      = wr && widx == 5'd12 && bus_wdata[31];
  assign start_ok  = start_req && !busy && !mmap_en && !slave_mode && !srst;
  assign bit_end   = busy && act && ph_cnt == hi_cnt;
  assign last      = bit_idx == cnt_m1;
  assign pos       = {bit_idx[IW-1:3], ~bit_idx[2:0]};

  assign sck_o  = cpol ^ (busy & act);
  assign cs_o   = cs_hi ? cs_act : ~cs_act;
  assign mosi_o = busy & dout_sel & buf_q[pos];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mmap_en    <= 1'b1;
      clk_src    <= 1'b0;
      div_n      <= '0;
      hi_cnt     <= '0;
      lo_cnt     <= '0;
      din_en     <= 1'b0;
      cpol       <= 1'b0;
      dout_sel   <= 1'b0;
      cnt_m1     <= '0;
      cs_hi      <= 1'b0;
      cs_hold    <= 1'b0;
      slave_mode <= 1'b0;
    end else if (wr) begin
      case (widx)
        5'd2:  mmap_en <= bus_wdata[17];
        5'd6:  begin
          clk_src <= bus_wdata[31];
          div_n   <= bus_wdata[17:12];
          hi_cnt  <= bus_wdata[11:6];
          lo_cnt  <= bus_wdata[5:0];
        end
        5'd7:  begin
          dout_sel <= bus_wdata[27];
          cpol     <= bus_wdata[7];
          din_en   <= bus_wdata[0];
        end
        5'd8:  cnt_m1 <= bus_wdata[25:17];
        5'd11: begin
          cs_hold <= bus_wdata[30];
          cs_hi   <= bus_wdata[23];
        end
        5'd12: slave_mode <= bus_wdata[30];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      act     <= 1'b0;
      ph_cnt  <= '0;
      bit_idx <= '0;
      rx_bit  <= 1'b0;
      cs_act  <= 1'b0;
    end else if (srst) begin
      busy   <= 1'b0;
      act    <= 1'b0;
      cs_act <= 1'b0;
    end else if (start_ok) begin
      busy    <= 1'b1;
      act     <= 1'b0;
      ph_cnt  <= '0;
      bit_idx <= '0;
      cs_act  <= 1'b1;
    end else if (busy) begin
      if (!act) begin
        if (ph_cnt == lo_cnt) begin
          act    <= 1'b1;
          ph_cnt <= '0;
          rx_bit <= miso_i;
        end else begin
          ph_cnt <= ph_cnt + 1'b1;
        end
      end else if (bit_end) begin
        act    <= 1'b0;
        ph_cnt <= '0;
        if (last) begin
          busy   <= 1'b0;
          cs_act <= cs_hold;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end else begin
        ph_cnt <= ph_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      done <= 1'b0;
    else if (srst)
      done <= 1'b0;
    else if (bit_end && last)
      done <= 1'b1;
    else if (wr && widx == 5'd12)
      done <= done & bus_wdata[4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      buf_q <= '0;
    else if (busy) begin
      if (bit_end && din_en)
        buf_q[pos] <= rx_bit;
    end else if (wr && bus_addr[6])
      buf_q[32*bus_addr[5:2] +: 32] <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[6])
      bus_rdata = buf_q[32*bus_addr[5:2] +: 32];
    else begin
      case (widx)
        5'd2:  bus_rdata = {14'b0, mmap_en, 17'b0};
        5'd6:  bus_rdata = {clk_src, 13'b0, div_n, hi_cnt, lo_cnt};
        5'd7:  bus_rdata = {4'b0, dout_sel, 19'b0, cpol, 6'b0, din_en};
        5'd8:  bus_rdata = {6'b0, cnt_m1, 17'b0};
        5'd11: bus_rdata = {1'b0, cs_hold, 6'b0, cs_hi, 23'b0};
        5'd12: bus_rdata = {1'b0, slave_mode, 25'b0, done, 4'b0};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sfc_master_chk.sv
module sfc_master_chk (
  input logic clk,
  input logic rst_n,
  input logic sck_o,
  input logic cs_o,
  input logic mosi_o,
  input logic busy,
  input logic done,
  input logic cpol,
  input logic cs_hi,
  input logic srst
);
  // R5: MOSI holds while SCK is away from its rest level
  a_r5_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sck_o != cpol && $past(sck_o) != $past(cpol)) |-> $stable(mosi_o));

  // R8: CS asserted for the whole transfer
  a_r8_cs_during_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cs_o == cs_hi);

  // R9: done only rises as a transfer ends
  a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));

  // R10: soft reset leaves the block quiet
  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!busy && !done && cs_o != cs_hi));

  // R5: idle clock level
  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> sck_o == cpol);
endmodule

bind sfc_master sfc_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sck_o(sck_o), .cs_o(cs_o), .mosi_o(mosi_o),
  .busy(busy), .done(done), .cpol(cpol), .cs_hi(cs_hi), .srst(srst)
);

// File: tb/sfc_master_tb_top.sv
module sfc_master_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, miso_i = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        sck_o, cs_o, mosi_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] tb_buf [64];
  logic [7:0] tx [64];
  logic [7:0] sl [64];

  sfc_master dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, a, e);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic check_buffer(input string req);
    logic [31:0] d;
    int bad = 0;
    for (int w = 0; w < 16; w++) begin
      rd(7'h40 + 7'(4*w), d);
      if (d !== {tb_buf[4*w+3], tb_buf[4*w+2], tb_buf[4*w+1], tb_buf[4*w]}) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic run_xfer(input int nb, input int lo, input int hi, input bit cpol, input bit cshi,
                          input bit hold, input bit din, input bit dout, input int restart_at, input string tag);
    int per, nbit, msck, mcs, mmosi;
    logic [31:0] d;
    per = lo + hi + 2; nbit = nb * 8; msck = 0; mcs = 0; mmosi = 0;
    wr(7'h18, 32'((hi << 6) | lo));
    wr(7'h1C, 32'((int'(dout) << 27) | (int'(cpol) << 7) | int'(din)));
    wr(7'h20, 32'((nbit - 1) << 17));
    wr(7'h2C, 32'((int'(hold) << 30) | (int'(cshi) << 23)));
    wr(7'h30, 32'h0);
    for (int b = 0; b < 64; b++) tx[b] = tb_buf[b];
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 7'h00; bus_wdata = 32'h0004_0000;
    @(posedge clk);
    for (int t = 0; t <= nbit * per; t++) begin
      logic es, ec, em;
      @(negedge clk);
      if (t == 0 || t == restart_at + 1) begin bus_sel = 0; bus_wr = 0; end
      if (t == restart_at) begin
        bus_sel = 1; bus_wr = 1; bus_addr = 7'h00; bus_wdata = 32'h0004_0000;
      end
      if (t < nbit * per) begin
        int k;
        k = t / per;
        miso_i = sl[k/8][7 - k%8];
        es = cpol ^ ((t % per) > lo);
        ec = cshi;
        em = dout ? tx[k/8][7 - k%8] : 1'b0;
      end else begin
        es = cpol;
        ec = hold ? cshi : ~cshi;
        em = 1'b0;
      end
      if (sck_o !== es) msck++;
      if (cs_o !== ec) mcs++;
      if (mosi_o !== em) mmosi++;
    end
    check(msck == 0, {tag, " R5 sck timing"}, msck, 0);
    check(mcs == 0, {tag, " R8 cs window"}, mcs, 0);
    check(mmosi == 0, {tag, " R4/R7 mosi bits"}, mmosi, 0);
    if (din) for (int b = 0; b < nb; b++) tb_buf[b] = sl[b];
    rd(7'h30, d);
    check(d[4] === 1'b1, {tag, " R9 done set"}, d, 32'h10);
    check_buffer({tag, " R6 buffer contents"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int bad;
    for (int i = 0; i < 64; i++) begin
      tb_buf[i] = 8'(i * 13 + 7);
      sl[i] = 8'hA5 ^ 8'(i * 37);
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1
    check(cs_o === 1'b1 && sck_o === 1'b0 && mosi_o === 1'b0, "R1 pins after reset",
          {29'b0, cs_o, sck_o, mosi_o}, 32'h4);
    rd(7'h08, d); check(d === 32'h0002_0000, "R1 control reset", d, 32'h0002_0000);
    rd(7'h30, d); check(d === 32'h0, "R1 status reset", d, 0);
    rd(7'h18, d); check(d === 32'h0, "R1 clock reset", d, 0);

    // R2
    wr(7'h18, 32'h8001_F0C3); rd(7'h18, d); check(d === 32'h8001_F0C3, "R2 clock readback", d, 32'h8001_F0C3);
    wr(7'h1C, 32'hFFFF_FFFF); rd(7'h1C, d); check(d === 32'h0800_0081, "R2 user readback", d, 32'h0800_0081);
    wr(7'h20, 32'hFFFF_FFFF); rd(7'h20, d); check(d === 32'h03FE_0000, "R2 count readback", d, 32'h03FE_0000);
    wr(7'h2C, 32'hFFFF_FFFF); rd(7'h2C, d); check(d === 32'h4080_0000, "R2 cs readback", d, 32'h4080_0000);
    wr(7'h1C, 0); wr(7'h2C, 0); wr(7'h18, 32'h41);

    // R3: blocked by read-path enable
    wr(7'h00, 32'h0004_0000);
    rd(7'h00, d); check(d === 32'h0, "R2 command reads zero", d, 0);
    bad = 0;
    repeat (6) begin @(negedge clk); if (cs_o !== 1'b1 || sck_o !== 1'b0) bad++; end
    check(bad == 0, "R3 start ignored with read path on", bad, 0);
    rd(7'h30, d); check(d[4] === 1'b0, "R3 no done with read path on", d, 0);
    wr(7'h08, 0);
    // R3: blocked by mode bit
    wr(7'h30, 32'h4000_0000);
    wr(7'h00, 32'h0004_0000);
    bad = 0;
    repeat (6) begin @(negedge clk); if (cs_o !== 1'b1 || sck_o !== 1'b0) bad++; end
    check(bad == 0, "R3 start ignored in non-master mode", bad, 0);
    rd(7'h30, d); check(d === 32'h4000_0000, "R3 mode readback no done", d, 32'h4000_0000);
    wr(7'h30, 0);

    for (int w = 0; w < 16; w++)
      wr(7'h40 + 7'(4*w), {tb_buf[4*w+3], tb_buf[4*w+2], tb_buf[4*w+1], tb_buf[4*w]});
    check_buffer("R4 buffer lanes");

    run_xfer(4, 1, 1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, -1, "A");
    run_xfer(3, 3, 0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, -1, "B");
    bad = 0;
    repeat (5) begin @(negedge clk); if (cs_o !== 1'b1) bad++; end
    check(bad == 0, "R8 cs held after transfer", bad, 0);
    run_xfer(2, 0, 2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, -1, "C chained");
    run_xfer(64, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, -1, "D full no capture");
    run_xfer(5, 2, 1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7, "E R11 restart no dout");

    // R9
    wr(7'h30, 32'h0); rd(7'h30, d); check(d[4] === 1'b0, "R9 done cleared", d, 0);
    wr(7'h30, 32'h10); rd(7'h30, d); check(d[4] === 1'b0, "R9 write one no set", d, 0);

    // R10
    wr(7'h18, 32'h41); wr(7'h1C, 32'h0800_0000); wr(7'h20, 32'(511 << 17));
    wr(7'h2C, 32'h4000_0000);
    wr(7'h00, 32'h0004_0000);
    repeat (30) @(negedge clk);
    check(cs_o === 1'b0, "R10 cs asserted before abort", cs_o, 0);
    wr(7'h30, 32'h8000_0000);
    check(cs_o === 1'b1, "R10 cs released by abort", cs_o, 1);
    bad = 0;
    repeat (10) begin @(negedge clk); if (sck_o !== 1'b0 || mosi_o !== 1'b0 || cs_o !== 1'b1) bad++; end
    check(bad == 0, "R10 pins quiet after abort", bad, 0);
    rd(7'h30, d); check(d === 32'h0, "R10 status after abort", d, 0);
    rd(7'h18, d); check(d === 32'h41, "R10 config kept", d, 32'h41);

    summary();
    $finish;
  end
endmodule